// File: doc/BRIEF.md
# Memory-Mapped Byte I/O Port

This block is a small peripheral for an 8-bit Z80-style host bus. It gives software one output byte and one input byte, both at a single memory location. A memory write to that location stores the data byte and drives it onto eight output pins, where it stays until the next write. A memory read from the same location places the eight input pins onto the data bus through tri-state drivers. The block also tells onboard memory to stay off the bus while the port is answering. The bidirectional bus is modelled as separate data-in, data-out and output-enable signals.

In the default narrow mode the port decodes all sixteen address lines and answers only at 0x407B (decimal 16507). That byte lies inside the host's system-variable RAM, so during a read the port drives the RAM chip-select high. When `wide_mode` is high, the port answers at every address from 0x2000 to 0x3FFF instead. That is the 8 KB window normally taken by a ROM mirror, so while the port is active in this mode it drives the ROM chip-select high.

A single controller FSM sequences each bus cycle. Its states are `S_IDLE`, `S_READ` and `S_WRITE`, and it moves between them through five named transitions:

- GO_RD: `S_IDLE` to `S_READ`. A qualified read hits the port. A read wins over a write if both strobes are low.
- GO_WR: `S_IDLE` to `S_WRITE`. A qualified write hits the port.
- RD_DONE: `S_READ` to `S_IDLE`. The read strobe or the qualification drops.
- WR_COMMIT: `S_WRITE` to `S_IDLE`. WR returns high while the cycle is still qualified and on the port's address. The held byte is copied to the output pins.
- WR_ABORT: `S_WRITE` to `S_IDLE`. The qualification or the address hit is lost before WR rises. Nothing is stored.

In any other condition a state holds.

Top module: `zio_byte_port`

## Requirements
- R1: While `rst_n` is low and after it is released, `pins_out` is 0x00, `bus_oe` is 0, `bus_dout` is 0x00, and `ram_inhibit` and `rom_inhibit` are 0.
- R2: In narrow mode, a qualified memory write to 0x407B updates `pins_out` with the written byte. `pins_out` then holds that value across any number of later cycles that do not commit a write.
- R3: The stored byte is the value `bus_din` held in the last clock sample with `wr_n` low. The update becomes visible one clock after the first sample with `wr_n` high. A change of `bus_din` at the moment WR rises is not stored.
- R4: In narrow mode, a qualified memory read of 0x407B raises `bus_oe` one clock after `rd_n` is sampled low. While `bus_oe` is high, `bus_dout` follows `pins_in` live. `bus_oe` falls one clock after `rd_n` returns high. `bus_dout` is 0x00 whenever `bus_oe` is 0.
- R5: During a narrow-mode read, `ram_inhibit` is 1 and `rom_inhibit` is 0. `ram_inhibit` is never 1 without `bus_oe`.
- R6: A cycle qualifies only when `mreq_n` is 0, `iorq_n` is 1 and `rfsh_n` is 1. A refresh cycle or an I/O-port cycle at a matching address neither enables the drivers nor changes `pins_out`.
- R7: In narrow mode, reads and writes to 0x407C (the reserved neighbour) and to 0x407A leave `bus_oe` at 0 and `pins_out` unchanged.
- R8: With `wide_mode` at 1, reads and writes to any address 0x2000–0x3FFF behave as in R2–R4. While the port is active, `rom_inhibit` is 1 and `ram_inhibit` is 0. Addresses 0x1FFF, 0x4000 and 0x407B get no response.
- R9: If the cycle loses its qualification or its address match before `wr_n` rises, the write is abandoned and `pins_out` keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the bus strobes |
| rst_n | input | 1 | Active-low asynchronous reset |
| wide_mode | input | 1 | 1 selects the 0x2000–0x3FFF window; 0 selects the single byte 0x407B |
| addr | input | 16 | Host address bus |
| bus_din | input | 8 | Data bus as seen by the port |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rfsh_n | input | 1 | Refresh indicator, active low |
| pins_in | input | 8 | Eight input pins to be read by the host |
| bus_dout | output | 8 | Byte the port places on the data bus |
| bus_oe | output | 1 | Tri-state enable for `bus_dout` |
| pins_out | output | 8 | Eight latched output pins |
| ram_inhibit | output | 1 | 1 drives the RAM chip-select high |
| rom_inhibit | output | 1 | 1 drives the ROM chip-select high |

## Verification
Two things meet on the clock where WR rises. The commit of the held byte into the output pins falls in the same sample as a fresh value arriving on `bus_din`. The bench provokes this by switching `bus_din` to a different byte in the same half-cycle that it releases `wr_n`. It then judges that `pins_out` shows the earlier byte one clock later. A second overlap is the live input path against the registered enable. The bench changes `pins_in` while `bus_oe` is already high and expects `bus_dout` to follow without waiting for another clock.

// File: rtl/zio_pkg.sv
package zio_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_READ  = 2'd1,
        S_WRITE = 2'd2
    } zio_state_e;

    localparam int unsigned ZIO_ADDR_W   = 16;
    localparam int unsigned ZIO_DATA_W   = 8;
    localparam logic [15:0] ZIO_PORT_AD  = 16'h407B;
    localparam logic [15:0] ZIO_WIN_BASE = 16'h2000;
    localparam int unsigned ZIO_WIN_BITS = 13;
endpackage

// File: rtl/zio_decode.sv
module zio_decode #(
    parameter int unsigned ADDR_W   = zio_pkg::ZIO_ADDR_W,
    parameter logic [ADDR_W-1:0] PORT_AD  = zio_pkg::ZIO_PORT_AD,
    parameter logic [ADDR_W-1:0] WIN_BASE = zio_pkg::ZIO_WIN_BASE,
    parameter int unsigned WIN_BITS = zio_pkg::ZIO_WIN_BITS,
    parameter bit HAS_WIDE = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide_mode,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rfsh_n,
    output logic              hit
);
    localparam int unsigned TAG_W = ADDR_W - WIN_BITS;

    logic qual;
    logic hit_narrow;
    logic hit_wide;

    // Only plain memory cycles qualify: no refresh, no I/O port access.
    assign qual       = !mreq_n && iorq_n && rfsh_n;
    assign hit_narrow = (addr == PORT_AD);

    generate
        if (HAS_WIDE) begin : g_wide
            assign hit_wide = (addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
        end else begin : g_narrow_only
            assign hit_wide = 1'b0;
        end
    endgenerate

    assign hit = qual && (wide_mode ? hit_wide : hit_narrow);

    // Unused low bits of the window base only set the window alignment.
    logic [TAG_W-1:0] unused_tag;
    assign unused_tag = '0;
endmodule

// File: rtl/zio_ctrl.sv
module zio_ctrl
    import zio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic rd_n,
    input  logic wr_n,
    input  logic wide_mode,
    output logic capture,
    output logic commit,
    output logic oe,
    output logic ram_inh,
    output logic rom_inh
);
    zio_state_e state_q, state_d;
    logic       mode_q, mode_d;

    // Next-state logic with named transitions.
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        unique case (state_q)
            S_IDLE: begin
                if (hit && !rd_n) begin          // GO_RD
                    state_d = S_READ;
                    mode_d  = wide_mode;
                end else if (hit && !wr_n) begin // GO_WR
                    state_d = S_WRITE;
                    mode_d  = wide_mode;
                end
            end
            S_READ: begin
                if (!hit || rd_n) state_d = S_IDLE;   // RD_DONE
            end
            S_WRITE: begin
                if (!hit)      state_d = S_IDLE;      // WR_ABORT
                else if (wr_n) state_d = S_IDLE;      // WR_COMMIT
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    // Output decode.
    always_comb begin
        capture = 1'b0;
        commit  = 1'b0;
        oe      = 1'b0;
        ram_inh = 1'b0;
        rom_inh = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                capture = hit && !wr_n && rd_n;
            end
            S_READ: begin
                oe      = 1'b1;
                ram_inh = !mode_q;
                rom_inh = mode_q;
            end
            S_WRITE: begin
                capture = hit && !wr_n;
                commit  = hit && wr_n;
                rom_inh = mode_q;
            end
            default: ;
        endcase
    end

    a_r4_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(!rd_n && hit));
    a_r9_commit_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (hit && !$past(wr_n)));
endmodule

// File: rtl/zio_latch.sv
module zio_latch #(
    parameter int unsigned DATA_W = zio_pkg::ZIO_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              commit,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            q      <= '0;
        end else begin
            if (capture) hold_q <= din;
            if (commit)  q      <= hold_q;
        end
    end

    a_r2_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(q));
endmodule

// File: rtl/zio_byte_port.sv
module zio_byte_port
    import zio_pkg::*;
#(
    parameter int unsigned ADDR_W = ZIO_ADDR_W,
    parameter int unsigned DATA_W = ZIO_DATA_W,
    parameter logic [ADDR_W-1:0] PORT_AD  = ZIO_PORT_AD,
    parameter logic [ADDR_W-1:0] WIN_BASE = ZIO_WIN_BASE,
    parameter int unsigned WIN_BITS = ZIO_WIN_BITS,
    parameter bit HAS_WIDE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              rfsh_n,
    input  logic [DATA_W-1:0] pins_in,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic [DATA_W-1:0] pins_out,
    output logic              ram_inhibit,
    output logic              rom_inhibit
);
    logic hit;
    logic capture;
    logic commit;

    zio_decode #(
        .ADDR_W  (ADDR_W),
        .PORT_AD (PORT_AD),
        .WIN_BASE(WIN_BASE),
        .WIN_BITS(WIN_BITS),
        .HAS_WIDE(HAS_WIDE)
    ) u_decode (
        .addr     (addr),
        .wide_mode(wide_mode),
        .mreq_n   (mreq_n),
        .iorq_n   (iorq_n),
        .rfsh_n   (rfsh_n),
        .hit      (hit)
    );

    zio_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .wide_mode(wide_mode),
        .capture  (capture),
        .commit   (commit),
        .oe       (bus_oe),
        .ram_inh  (ram_inhibit),
        .rom_inh  (rom_inhibit)
    );

    zio_latch #(.DATA_W(DATA_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .capture(capture),
        .commit (commit),
        .din    (bus_din),
        .q      (pins_out)
    );

    // Input pins reach the bus only while the drivers are enabled.
    assign bus_dout = bus_oe ? pins_in : '0;

    a_r6_refresh_drops_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (!rfsh_n || !iorq_n || mreq_n) |=> !bus_oe);
    a_r5_ram_inh_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
        ram_inhibit |-> (bus_oe && !rom_inhibit));
    a_r3_update_after_wr_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pins_out) |-> ($past(wr_n) && !$past(wr_n, 2)));
    a_r4_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_dout == '0));
endmodule

// File: tb/zio_byte_port_tb.sv
module zio_byte_port_tb;
    typedef struct {
        string      req;
        int         kind;   // 0 pins_out, 1 bus_dout, 2 bus_oe, 3 ram_inhibit, 4 rom_inhibit
        logic [7:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  bus_din = 8'h00;
    logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rfsh_n = 1'b1;
    logic [7:0]  pins_in = 8'h00;
    logic [7:0]  bus_dout, pins_out;
    logic        bus_oe, ram_inhibit, rom_inhibit;

    item_t queue_q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [7:0] exp_out = 8'h00;

    always #4 clk = ~clk;

    zio_byte_port u_dut (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .addr(addr),
        .bus_din(bus_din), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n),
        .wr_n(wr_n), .rfsh_n(rfsh_n), .pins_in(pins_in), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .pins_out(pins_out), .ram_inhibit(ram_inhibit),
        .rom_inhibit(rom_inhibit)
    );

    // Monitor: pops expectations one time unit after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (queue_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = queue_q.pop_front();
                case (it.kind)
                    0: act = pins_out;
                    1: act = bus_dout;
                    2: act = {7'd0, bus_oe};
                    3: act = {7'd0, ram_inhibit};
                    default: act = {7'd0, rom_inhibit};
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_v(input string req, input int kind, input logic [7:0] v);
        item_t it;
        it.req = req; it.kind = kind; it.exp = v;
        queue_q.push_back(it);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_bus();
        mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; rfsh_n = 1'b1;
    endtask

    // Write: WR low for two samples, then WR rises while bus_din switches to late_d.
    task automatic wr_cycle(input logic [15:0] a, input logic [7:0] d, input logic [7:0] late_d,
                            input bit iorq_low, input bit rfsh_low);
        addr = a; bus_din = d; mreq_n = 1'b0; wr_n = 1'b0;
        iorq_n = !iorq_low; rfsh_n = !rfsh_low;
        tick(); tick();
        wr_n = 1'b1; bus_din = late_d;
        tick();
        idle_bus();
        tick();
    endtask

    task automatic rd_open(input logic [15:0] a, input bit iorq_low, input bit rfsh_low);
        addr = a; mreq_n = 1'b0; rd_n = 1'b0;
        iorq_n = !iorq_low; rfsh_n = !rfsh_low;
        tick();
    endtask

    task automatic rd_close();
        idle_bus();
        tick();
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        tick();
        expect_v("R1", 0, 8'h00); expect_v("R1", 2, 8'h00); expect_v("R1", 1, 8'h00);
        expect_v("R1", 3, 8'h00); expect_v("R1", 4, 8'h00);
        tick();
        rst_n = 1'b1;
        tick();
        expect_v("R1", 0, 8'h00); expect_v("R1", 2, 8'h00);
        tick();

        // R2 and R3: narrow write, late data change ignored.
        wr_cycle(16'h407B, 8'hA5, 8'h3C, 0, 0);
        exp_out = 8'hA5;
        expect_v("R2", 0, exp_out);
        expect_v("R3", 0, exp_out);
        tick(); tick();
        expect_v("R2", 0, exp_out);
        wr_cycle(16'h407B, 8'h5A, 8'hFF, 0, 0);
        exp_out = 8'h5A;
        expect_v("R2", 0, exp_out);

        // R3: update timing, visible one clock after WR rises.
        addr = 16'h407B; bus_din = 8'hC3; mreq_n = 1'b0; wr_n = 1'b0;
        tick(); tick();
        wr_n = 1'b1;
        expect_v("R3", 0, 8'h5A);
        tick();
        exp_out = 8'hC3;
        expect_v("R3", 0, exp_out);
        idle_bus(); tick();

        // R4 and R5: narrow read with live pin tracking.
        pins_in = 8'h81;
        rd_open(16'h407B, 0, 0);
        expect_v("R4", 2, 8'h01); expect_v("R4", 1, 8'h81);
        expect_v("R5", 3, 8'h01); expect_v("R5", 4, 8'h00);
        tick();
        pins_in = 8'h7E;
        expect_v("R4", 1, 8'h7E);
        tick();
        rd_close();
        expect_v("R4", 2, 8'h00); expect_v("R4", 1, 8'h00); expect_v("R5", 3, 8'h00);
        tick();

        // R6: refresh and I/O cycles do nothing.
        rd_open(16'h407B, 0, 1);
        expect_v("R6", 2, 8'h00);
        rd_close();
        rd_open(16'h407B, 1, 0);
        expect_v("R6", 2, 8'h00);
        rd_close();
        wr_cycle(16'h407B, 8'h11, 8'h11, 0, 1);
        expect_v("R6", 0, exp_out);
        wr_cycle(16'h407B, 8'h22, 8'h22, 1, 0);
        expect_v("R6", 0, exp_out);

        // R7: reserved neighbour and lower neighbour.
        wr_cycle(16'h407C, 8'h33, 8'h33, 0, 0);
        expect_v("R7", 0, exp_out);
        rd_open(16'h407C, 0, 0);
        expect_v("R7", 2, 8'h00);
        rd_close();
        wr_cycle(16'h407A, 8'h44, 8'h44, 0, 0);
        expect_v("R7", 0, exp_out);

        // R9: write abandoned when MREQ drops before WR rises.
        addr = 16'h407B; bus_din = 8'h99; mreq_n = 1'b0; wr_n = 1'b0;
        tick(); tick();
        mreq_n = 1'b1;
        tick();
        wr_n = 1'b1;
        tick(); tick();
        expect_v("R9", 0, exp_out);
        tick();

        // R8: wide mode window.
        wide_mode = 1'b1;
        tick();
        addr = 16'h2345; bus_din = 8'h6D; mreq_n = 1'b0; wr_n = 1'b0;
        tick();
        expect_v("R8", 4, 8'h01); expect_v("R8", 3, 8'h00);
        tick();
        wr_n = 1'b1;
        tick();
        idle_bus(); tick();
        exp_out = 8'h6D;
        expect_v("R8", 0, exp_out);
        pins_in = 8'hE7;
        rd_open(16'h3FFF, 0, 0);
        expect_v("R8", 2, 8'h01); expect_v("R8", 1, 8'hE7);
        expect_v("R8", 4, 8'h01); expect_v("R8", 3, 8'h00);
        rd_close();
        expect_v("R8", 4, 8'h00);
        rd_open(16'h1FFF, 0, 0);
        expect_v("R8", 2, 8'h00);
        rd_close();
        rd_open(16'h4000, 0, 0);
        expect_v("R8", 2, 8'h00);
        rd_close();
        wr_cycle(16'h407B, 8'h12, 8'h12, 0, 0);
        expect_v("R8", 0, exp_out);
        wr_cycle(16'h2000, 8'hF0, 8'h0F, 0, 0);
        exp_out = 8'hF0;
        expect_v("R8", 0, exp_out);
        tick(); tick();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule